// File: doc/BRIEF.md
# Square Wave Baud Generator

A programmable 16-bit divider that turns the input clock into a square wave whose period is N clocks. It is meant for baud-rate clocks. The output is high for the first half of each period and low for the second half. When N is odd, the high half is one clock longer than the low half. Internally the count drops by two on each clock. After a load, the first decrement is one in the high phase of an odd count and three in the low phase. Every other decrement is two.

Software first issues a control write. That write stops the block, forces the output high and selects binary or decimal (BCD) counting. Software then writes the count as two bytes, low byte first. The counter loads on the next clock. A gate input enables counting while it is high and holds counting while it is low. A low gate also forces the output high without waiting for a clock. A rising gate restarts the period, so an external event can resynchronise the wave. A count written while the block runs takes effect when the current half-period ends, or sooner if a gate trigger arrives first.

Top module: `sqwave_gen`

## Requirements
- R1: After reset, and after any control write, out_wave is high and the divider stays idle until a full count has been written.
- R2: A count is written with two cnt_wr strobes: the low byte first, then the high byte. The divider loads it on the clock edge after the second strobe, and out_wave is high from that edge.
- R3: For an even count N, out_wave stays high for N/2 clocks and then low for N/2 clocks, repeating indefinitely.
- R4: For an odd count N, out_wave stays high for (N+1)/2 clocks and then low for (N-1)/2 clocks, repeating indefinitely.
- R5: While gate is low, counting holds and out_wave is high. If gate falls while out_wave is low, out_wave goes high in the same cycle, without a clock edge.
- R6: On the first clock edge at which gate is sampled high after being sampled low, the divider reloads the count and starts a new high phase.
- R7: A count written while the divider runs leaves the current half-period unchanged. The new count governs from the next half-period boundary, or from the next gate trigger if that comes first.
- R8: In binary mode (ctl_bcd = 0 at the control write), a count of 0 means 65536.
- R9: In BCD mode (ctl_bcd = 1), the count is read as four decimal digits, with bits 15:12 the thousands digit and bits 3:0 the units digit. A count of 0 means 10000.
- R10: The minimum count of 2 gives one clock high and one clock low. The internal count never reaches zero while the divider runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control write: stops the divider and latches ctl_bcd |
| ctl_bcd | input | 1 | Counting base taken at a control write (1 = BCD) |
| cnt_wr | input | 1 | Count byte strobe, low byte then high byte |
| cnt_byte | input | 8 | Count byte value |
| gate | input | 1 | Level enable; a rising edge restarts the period |
| out_wave | output | 1 | Square wave output |

## Verification
Every state change of out_wave lands on the clock edge that samples the stimulus. This covers a load after the second count byte, a half-period expiry and a gate trigger. The one exception is a low gate, which raises out_wave within the same cycle through logic alone. The bench holds its inputs across each rising edge. It steps a behavioural model of the phase lengths on that edge and compares out_wave against the model on the following falling edge. That point falls after the registered update and after any combinational gate effect. Long runs with counts of 0 in both bases cover the full-range half-periods.

// File: rtl/sqwave_gen.sv
module sqwave_gen #(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       ctl_bcd,
  input  logic       cnt_wr,
  input  logic [7:0] cnt_byte,
  input  logic       gate,
  output logic       out_wave
);
  localparam int CW = W + 1;
  localparam int ND = W / 4;

  logic          bcd, ptr, fresh, running, out_q, first, odd_q, gate_q;
  logic [7:0]    lo_q;
  logic [W-1:0]  init_q;
  logic [CW-1:0] cnt, n_eff;
  logic [1:0]    step;
  logic          expire, trig;

  function automatic logic [CW-1:0] eff_count(input logic [W-1:0] v, input logic dec);
    logic [CW-1:0] acc;
    acc = '0;
    if (dec) begin
      for (int i = ND - 1; i >= 0; i--)
        acc = acc * CW'(10) + CW'(v[i*4 +: 4]);
      if (v == '0) acc = CW'(10 ** ND);
    end else begin
      acc = {1'b0, v};
      if (v == '0) acc = {1'b1, {W{1'b0}}};
    end
    return acc;
  endfunction

  assign n_eff    = eff_count(init_q, bcd);
  assign step     = !first ? 2'd2 : (!odd_q ? 2'd2 : (out_q ? 2'd1 : 2'd3));
  assign expire   = cnt <= CW'(step);
  assign trig     = gate && !gate_q;
  assign out_wave = out_q | ~gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcd <= 1'b0; ptr <= 1'b0; fresh <= 1'b0; running <= 1'b0;
      out_q <= 1'b1; first <= 1'b0; odd_q <= 1'b0; gate_q <= 1'b0;
      lo_q <= '0; init_q <= '0; cnt <= '0;
    end else begin
      gate_q <= gate;
      if (ctl_wr) begin
        bcd <= ctl_bcd; ptr <= 1'b0; fresh <= 1'b0;
        running <= 1'b0; out_q <= 1'b1; first <= 1'b0;
      end else begin
        if (!running) begin
          if (fresh) begin
            cnt <= n_eff; odd_q <= n_eff[0]; first <= 1'b1;
            out_q <= 1'b1; running <= 1'b1; fresh <= 1'b0;
          end
        end else if (!gate) begin
          out_q <= 1'b1;
        end else if (trig) begin
          cnt <= n_eff; odd_q <= n_eff[0]; first <= 1'b1;
          out_q <= 1'b1; fresh <= 1'b0;
        end else if (expire) begin
          cnt <= n_eff; odd_q <= n_eff[0]; first <= 1'b1;
          out_q <= ~out_q; fresh <= 1'b0;
        end else begin
          cnt <= cnt - CW'(step); first <= 1'b0;
        end
        if (cnt_wr) begin
          if (!ptr) lo_q <= cnt_byte;
          else begin
            init_q <= W'({cnt_byte, lo_q});
            fresh  <= 1'b1;
          end
          ptr <= ~ptr;
        end
      end
    end
  end

  p_ctl_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (out_q && !running));
  p_second_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && cnt_wr && ptr) |=> fresh);
  p_gate_low_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && running && !gate) |=> out_q);
  p_fall_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> $past(gate));
  p_trig_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr && running && gate && !gate_q) |=> (out_q && first));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> cnt != '0);
endmodule

// File: tb/sqwave_gen_bench.sv
module sqwave_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0, ctl_bcd = 1'b0;
  logic cnt_wr = 1'b0, gate = 1'b1;
  logic [7:0] cnt_byte = '0;
  logic out_wave;
  int errors = 0, checks = 0, cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  sqwave_gen u_sqwave_gen (.clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_bcd(ctl_bcd),
    .cnt_wr(cnt_wr), .cnt_byte(cnt_byte), .gate(gate), .out_wave(out_wave));

  // behavioural model: phase level and clocks left in the phase
  bit m_run, m_lvl = 1'b1, m_fresh, m_ptr, m_bcd, m_gq;
  int m_rem, m_n;
  int m_lo, m_init;

  function automatic int value_of(int v, bit dec);
    int r;
    if (dec) r = ((v >> 12) & 15) * 1000 + ((v >> 8) & 15) * 100 + ((v >> 4) & 15) * 10 + (v & 15);
    else r = v;
    if (v == 0) r = dec ? 10000 : 65536;
    return r;
  endfunction

  task automatic m_load();
    m_n = value_of(m_init, m_bcd);
    m_lvl = 1'b1;
    m_rem = (m_n + 1) / 2;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_lvl = 1; m_fresh = 0; m_ptr = 0; m_bcd = 0; m_gq = 0; m_init = 0; m_lo = 0;
    end else begin
      if (ctl_wr) begin
        m_bcd = ctl_bcd; m_ptr = 0; m_fresh = 0; m_run = 0; m_lvl = 1;
      end else begin
        if (!m_run) begin
          if (m_fresh) begin m_load(); m_run = 1; m_fresh = 0; end
        end else if (!gate) m_lvl = 1;
        else if (!m_gq) begin m_load(); m_fresh = 0; end
        else begin
          m_rem--;
          if (m_rem == 0) begin
            m_n = value_of(m_init, m_bcd);
            m_lvl = !m_lvl;
            m_rem = m_lvl ? (m_n + 1) / 2 : m_n / 2;
            m_fresh = 0;
          end
        end
        if (cnt_wr) begin
          if (!m_ptr) m_lo = int'(cnt_byte);
          else begin m_init = (int'(cnt_byte) << 8) | m_lo; m_fresh = 1; end
          m_ptr = !m_ptr;
        end
      end
      m_gq = gate;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      automatic logic exp = m_lvl | !gate;
      checks++;
      if (out_wave !== exp) begin
        errors++;
        $display("FAIL %s: out_wave=%b expected %b at cycle %0d", tag, out_wave, exp, cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 195000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected under 195000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_ctl(bit dec);
    ctl_wr = 1; ctl_bcd = dec; run(1); ctl_wr = 0;
  endtask

  task automatic do_cnt(logic [15:0] v);
    cnt_wr = 1; cnt_byte = v[7:0]; run(1);
    cnt_byte = v[15:8]; run(1);
    cnt_wr = 0;
  endtask

  initial begin
    tag = "R1"; run(3); rst_n = 1; run(4);
    do_ctl(0); run(10);
    tag = "R2"; do_cnt(16'd4); run(3);
    tag = "R3"; run(30);
    do_cnt(16'd6); run(40);
    tag = "R1"; do_ctl(0); run(8);
    tag = "R4"; do_cnt(16'd5); run(40);
    tag = "R7"; run(1); do_cnt(16'd3); run(30);
    tag = "R4"; do_cnt(16'd7); run(50);
    tag = "R5"; run(5); gate = 0; run(6); gate = 1; run(30);
    run(2); gate = 0; #1 run(3); gate = 1; run(20);
    tag = "R6"; run(3); gate = 0; run(1); gate = 1; run(25);
    tag = "R7"; do_cnt(16'd9); run(1); gate = 0; run(1); gate = 1; run(40);
    tag = "R10"; do_ctl(0); do_cnt(16'd2); run(30);
    tag = "R9"; do_ctl(1); do_cnt(16'h0015); run(80);
    do_ctl(1); do_cnt(16'h0000); run(21000);
    tag = "R8"; do_ctl(0); do_cnt(16'h0000); run(70000);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule